// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a 256-byte serial memory. It receives the clock and data lines of a two-wire bus as raw samples and cleans each one with a synchronizer and a majority filter. From the cleaned lines it detects START and STOP conditions and decodes the transaction. It drives the data line only through an open-drain pull-low output. The memory array, the nonvolatile write timing and the protection policy sit outside. Reads go through a combinational memory read port. Writes are collected in a 16-byte page buffer and handed to a write sequencer in a single commit pulse.

A transaction starts with a device byte. Its upper nibble is the memory device type 1010, the next three bits must equal the board strap inputs, and the last bit selects read (1) or write (0). A write then carries a word address and up to a page of data. A read streams bytes from an internal pointer until the master answers with a high acknowledge. A random read is a write that carries only the word address, followed by a repeated START and a read device byte. The sequencer's busy flag makes the slave refuse its device byte, so a master can poll for the end of a write cycle.

Top module: `twsmem_slave`

## Requirements
- R1: The device byte is acknowledged only when bits [7:4] are 1010 and bits [3:1] equal `strap`. On a mismatch no acknowledge is given, and every later byte is ignored until the next START.
- R2: Data is sampled on the rising edge of the filtered clock line. `sda_pull` changes only after a filtered falling edge, so it is steady while the clock is high.
- R3: In a write, the device byte, the word address byte and each accepted data byte are acknowledged by pulling the data line low for the whole ninth clock.
- R4: Data byte k of a write is stored at page index (word address[3:0] + k) mod 16, with address bits [7:4] fixed. A 17th byte therefore overwrites the first one. At commit, `commit_base` carries bits [7:4] with the low nibble zero, bit i of `commit_mask` marks index i as written, and byte i sits in `commit_data[8i+7:8i]`.
- R5: A STOP that ends a write holding at least one stored data byte raises `commit_pulse` for exactly one clock. A STOP with no stored data raises nothing.
- R6: A read shifts out 8 bits, MSB first, and then releases the line. A low master acknowledge brings the next byte. A high acknowledge ends the output, and the line stays released until a START.
- R7: Each byte sent advances the read pointer by one across the full 256-byte space, wrapping from FFh to 00h. A current read returns the byte after the last one accessed.
- R8: A write carrying only a word address, followed by a repeated START and a read device byte, returns the byte at that word address.
- R9: A START abandons any uncommitted page data, so a START followed by a STOP commits nothing.
- R10: While `seq_busy` is high at the eighth bit of the device byte, that byte is not acknowledged.
- R11: A data byte received while `ack_allow` is low gets no acknowledge and is not stored. The rest of that command is ignored.
- R12: After reset, `sda_pull` and `commit_pulse` are low and the read pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line sample |
| sda_in | input | 1 | Raw bus data line sample (wired level) |
| sda_pull | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Device select straps compared with device byte bits [3:1] |
| seq_busy | input | 1 | Write sequencer busy; refuses the device byte |
| ack_allow | input | 1 | Protection verdict; low refuses data bytes |
| mem_raddr | output | ADDR_W | Read address into the array |
| mem_rdata | input | 8 | Array data at `mem_raddr`, combinational |
| commit_pulse | output | 1 | One-clock page commit strobe |
| commit_base | output | ADDR_W | Page base address, low nibble zero |
| commit_mask | output | 16 | Written-byte mask, bit i for page index i |
| commit_data | output | 128 | Page bytes, index i at bits [8i+7:8i] |

## Verification
A wrong decode state shows at the ports within one byte time. The slave then gives a missing or extra acknowledge in the ninth clock, or read bits that no longer match the expected stored byte. A pointer fault does not appear until the next read, where a byte from the wrong address comes out. The scenarios therefore pair every write with a later random, current or sequential read. Page-buffer faults show at the commit pulse itself, through its base, mask and data, and again in the bytes read back from the bench's memory model.

// File: rtl/twsmem_pkg.sv
package twsmem_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_WORD,
      ST_DATA,
      ST_ACK,
      ST_READ,
      ST_MACK,
      ST_IGNORE
   } twsm_state_e;

   localparam logic [3:0] DEV_TYPE_MEM = 4'b1010;
   localparam int         BYTE_W       = 8;
endpackage

// File: rtl/twsmem_linefilt.sv
module twsmem_linefilt #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_TAPS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("twsmem_linefilt: SYNC_STAGES must be at least 2");
   end
   if (FILT_TAPS < 1 || (FILT_TAPS % 2) == 0) begin : g_chk_taps
      $error("twsmem_linefilt: FILT_TAPS must be odd and positive");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   clean_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
   end

   if (FILT_TAPS == 1) begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) clean_q <= 1'b1;
         else        clean_q <= sync_q[SYNC_STAGES-1];
      end
   end else begin : g_majority
      logic [FILT_TAPS-1:0] taps_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            taps_q  <= '1;
            clean_q <= 1'b1;
         end else begin
            taps_q  <= {taps_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            clean_q <= ($countones(taps_q) > (FILT_TAPS / 2));
         end
      end
   end

   assign clean = clean_q;
endmodule

// File: rtl/twsmem_busevt.sv
module twsmem_busevt (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_e,
   output logic stop_e
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise = scl & ~scl_q;
   assign scl_fall = ~scl & scl_q;
   assign start_e  = scl & scl_q & sda_q & ~sda;
   assign stop_e   = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/twsmem_pagebuf.sv
module twsmem_pagebuf #(
   parameter int PAGE_W = 4,
   localparam int PAGE_BYTES = 1 << PAGE_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    wr_en,
   input  logic [PAGE_W-1:0]       wr_idx,
   input  logic [7:0]              wr_byte,
   output logic [PAGE_BYTES-1:0]   mask,
   output logic [8*PAGE_BYTES-1:0] data
);
   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
      localparam logic [PAGE_W-1:0] SLOT = PAGE_W'(i);
      logic [7:0] byte_q;
      logic       vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
            vld_q  <= 1'b0;
         end else if (clr) begin
            vld_q  <= 1'b0;
         end else if (wr_en && wr_idx == SLOT) begin
            byte_q <= wr_byte;
            vld_q  <= 1'b1;
         end
      end
      assign data[8*i +: 8] = byte_q;
      assign mask[i]        = vld_q;
   end

   // R4: a store marks its slot valid in the following cycle
   assert_store_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> mask[$past(wr_idx)]);
endmodule

// File: rtl/twsmem_slave.sv
module twsmem_slave
   import twsmem_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int PAGE_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_TAPS   = 3,
   localparam int PAGE_BYTES = 1 << PAGE_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_in,
   input  logic                    sda_in,
   output logic                    sda_pull,
   input  logic [2:0]              strap,
   input  logic                    seq_busy,
   input  logic                    ack_allow,
   output logic [ADDR_W-1:0]       mem_raddr,
   input  logic [7:0]              mem_rdata,
   output logic                    commit_pulse,
   output logic [ADDR_W-1:0]       commit_base,
   output logic [PAGE_BYTES-1:0]   commit_mask,
   output logic [8*PAGE_BYTES-1:0] commit_data
);
   if (ADDR_W > BYTE_W || PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_chk_geom
      $error("twsmem_slave: need 1 <= PAGE_W < ADDR_W <= 8");
   end

   localparam int HI_W = ADDR_W - PAGE_W;

   logic scl_f, sda_f;
   logic scl_rise, scl_fall, start_e, stop_e;

   twsmem_linefilt #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .raw(scl_in), .clean(scl_f));
   twsmem_linefilt #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .raw(sda_in), .clean(sda_f));

   twsmem_busevt u_evt (
      .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_e(start_e), .stop_e(stop_e));

   twsm_state_e       st_q, nxt_q, dec_nxt;
   logic [3:0]        bitcnt_q;
   logic [6:0]        shreg_q;
   logic [7:0]        nb, txbyte_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [HI_W-1:0]   page_hi_q;
   logic              ack_q, dec_ack, macked_q, pull_q, commit_q;
   logic              receiving, byte_done, buf_wr, buf_clr;
   logic [PAGE_BYTES-1:0] buf_mask;

   assign nb        = {shreg_q, sda_f};
   assign receiving = (st_q == ST_ADDR) || (st_q == ST_WORD) || (st_q == ST_DATA);
   assign byte_done = receiving && scl_rise && (bitcnt_q == 4'd7) && !start_e && !stop_e;

   always_comb begin
      dec_ack = 1'b0;
      dec_nxt = ST_IGNORE;
      unique case (st_q)
         ST_ADDR: if (nb[7:4] == DEV_TYPE_MEM && nb[3:1] == strap && !seq_busy) begin
            dec_ack = 1'b1;
            dec_nxt = nb[0] ? ST_READ : ST_WORD;
         end
         ST_WORD: begin
            dec_ack = 1'b1;
            dec_nxt = ST_DATA;
         end
         ST_DATA: if (ack_allow) begin
            dec_ack = 1'b1;
            dec_nxt = ST_DATA;
         end
         default: ;
      endcase
   end

   assign buf_wr  = byte_done && (st_q == ST_DATA) && ack_allow;
   assign buf_clr = start_e || commit_q;

   twsmem_pagebuf #(.PAGE_W(PAGE_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
      .wr_idx(ptr_q[PAGE_W-1:0]), .wr_byte(nb),
      .mask(buf_mask), .data(commit_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         nxt_q     <= ST_IDLE;
         bitcnt_q  <= '0;
         shreg_q   <= '0;
         txbyte_q  <= '0;
         ptr_q     <= '0;
         page_hi_q <= '0;
         ack_q     <= 1'b0;
         macked_q  <= 1'b0;
         pull_q    <= 1'b0;
         commit_q  <= 1'b0;
      end else begin
         commit_q <= 1'b0;
         if (start_e) begin
            st_q     <= ST_ADDR;
            bitcnt_q <= '0;
            pull_q   <= 1'b0;
         end else if (stop_e) begin
            commit_q <= |buf_mask;
            st_q     <= ST_IDLE;
            pull_q   <= 1'b0;
         end else begin
            unique case (st_q)
               ST_ADDR, ST_WORD, ST_DATA: begin
                  if (scl_rise) begin
                     shreg_q  <= nb[6:0];
                     bitcnt_q <= bitcnt_q + 4'd1;
                     if (byte_done) begin
                        ack_q <= dec_ack;
                        nxt_q <= dec_nxt;
                        if (st_q == ST_WORD) ptr_q <= nb[ADDR_W-1:0];
                        if (buf_wr) begin
                           page_hi_q <= ptr_q[ADDR_W-1:PAGE_W];
                           ptr_q     <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
                        end
                     end
                  end else if (scl_fall && bitcnt_q == 4'd8) begin
                     pull_q <= ack_q;
                     st_q   <= ack_q ? ST_ACK : ST_IGNORE;
                  end
               end
               ST_ACK: if (scl_fall) begin
                  bitcnt_q <= '0;
                  st_q     <= nxt_q;
                  if (nxt_q == ST_READ) begin
                     txbyte_q <= mem_rdata;
                     pull_q   <= ~mem_rdata[7];
                     ptr_q    <= ptr_q + 1'b1;
                  end else begin
                     pull_q   <= 1'b0;
                  end
               end
               ST_READ: begin
                  if (scl_rise) begin
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt_q == 4'd8) begin
                        pull_q <= 1'b0;
                        st_q   <= ST_MACK;
                     end else begin
                        pull_q <= ~txbyte_q[3'(4'd7 - bitcnt_q)];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     macked_q <= ~sda_f;
                  end else if (scl_fall) begin
                     bitcnt_q <= '0;
                     if (macked_q) begin
                        txbyte_q <= mem_rdata;
                        pull_q   <= ~mem_rdata[7];
                        ptr_q    <= ptr_q + 1'b1;
                        st_q     <= ST_READ;
                     end else begin
                        st_q     <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull     = pull_q;
   assign mem_raddr    = ptr_q;
   assign commit_pulse = commit_q;
   assign commit_base  = {page_hi_q, {PAGE_W{1'b0}}};
   assign commit_mask  = buf_mask;

   // R1: a refused command leaves the line released
   assert_ignore_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IGNORE) |-> !pull_q);
   // R2: the slave starts pulling only after a clock falling edge
   assert_pull_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_q) |-> $past(scl_fall));
   // R5: commit lasts one cycle
   assert_commit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |=> !commit_q);
   // R5: commit only carries a non-empty page
   assert_commit_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> (buf_mask != '0));
endmodule

// File: tb/twsmem_slave_bench.sv
`timescale 1ns/1ps
module twsmem_slave_bench;
   localparam int Q = 16;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic seq_busy = 1'b0, ack_allow = 1'b1;
   logic sda_pull, commit_pulse;
   logic [7:0] mem_raddr, mem_rdata, commit_base;
   logic [15:0] commit_mask;
   logic [127:0] commit_data;
   logic sda_line;
   logic [7:0] mem [256] = '{default: 8'hFF};

   int checks = 0, failures = 0, commit_cnt = 0;
   logic [7:0]   last_base;
   logic [15:0]  last_mask;
   logic [127:0] last_data;

   always #2.5 clk = ~clk;

   assign sda_line  = m_sda & ~sda_pull;
   assign mem_rdata = mem[mem_raddr];

   twsmem_slave u_twsmem_slave (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
      .sda_pull(sda_pull), .strap(STRAP), .seq_busy(seq_busy),
      .ack_allow(ack_allow), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
      .commit_pulse(commit_pulse), .commit_base(commit_base),
      .commit_mask(commit_mask), .commit_data(commit_data));

   always @(posedge clk) begin
      if (commit_pulse) begin
         commit_cnt <= commit_cnt + 1;
         last_base  <= commit_base;
         last_mask  <= commit_mask;
         last_data  <= commit_data;
         for (int i = 0; i < 16; i++)
            if (commit_mask[i]) mem[commit_base + 8'(i)] <= commit_data[8*i +: 8];
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; idle(Q);
      m_scl = 1'b1; idle(Q);
      m_sda = 1'b0; idle(Q);
      m_scl = 1'b0; idle(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; idle(Q);
      m_scl = 1'b1; idle(Q);
      m_sda = 1'b1; idle(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ackl);
      logic a1;
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; idle(Q);
         m_scl = 1'b1; idle(2*Q);
         m_scl = 1'b0; idle(Q);
      end
      m_sda = 1'b1; idle(Q);
      m_scl = 1'b1; idle(1);
      a1 = sda_line;
      idle(2*Q - 1);
      check("R2 ack level steady while clock high", a1, sda_line);
      ackl = ~sda_line;
      m_scl = 1'b0; idle(Q);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         idle(Q);
         m_scl = 1'b1; idle(Q);
         b[i] = sda_line;
         idle(Q);
         m_scl = 1'b0; idle(Q);
      end
      m_sda = ~mack; idle(Q);
      m_scl = 1'b1; idle(2*Q);
      m_scl = 1'b0; idle(Q);
      m_sda = 1'b1;
   endtask

   task automatic set_read_addr(input logic [7:0] a);
      logic k;
      bus_start();
      send_byte(DEVW, k); check("R8 device write ack", k, 1);
      send_byte(a, k);    check("R8 word address ack", k, 1);
      bus_start();
      send_byte(DEVR, k); check("R8 device read ack", k, 1);
   endtask

   task automatic t_reset();
      check("R12 sda_pull after reset", sda_pull, 0);
      check("R12 commit_pulse after reset", commit_pulse, 0);
   endtask

   task automatic t_byte_write();
      logic k;
      int c0 = commit_cnt;
      bus_start();
      send_byte(DEVW, k);  check("R3 device byte ack", k, 1);
      send_byte(8'h35, k); check("R3 word byte ack", k, 1);
      send_byte(8'hA5, k); check("R3 data byte ack", k, 1);
      bus_stop();
      check("R5 one commit", commit_cnt - c0, 1);
      check("R4 commit base", last_base, 8'h30);
      check("R4 commit mask", last_mask, 16'h0020);
      check("R4 commit byte 5", last_data[40 +: 8], 8'hA5);
   endtask

   task automatic t_page_wrap();
      logic k;
      logic all_ack = 1'b1;
      bus_start();
      send_byte(DEVW, k);
      send_byte(8'h4E, k);
      for (int j = 0; j < 18; j++) begin
         send_byte(8'(8'h10 + j), k);
         all_ack &= k;
      end
      bus_stop();
      check("R3 all page bytes acked", all_ack, 1);
      check("R4 wrap base", last_base, 8'h40);
      check("R4 wrap mask full", last_mask, 16'hFFFF);
      for (int i = 0; i < 16; i++)
         check("R4 wrapped page byte", last_data[8*i +: 8], 8'(8'h12 + i));
   endtask

   task automatic t_random_read();
      logic [7:0] d;
      set_read_addr(8'h45);
      recv_byte(1'b1, d); check("R8 random read byte", d, 8'h17);
      recv_byte(1'b1, d); check("R6 sequential byte 2", d, 8'h18);
      recv_byte(1'b0, d); check("R6 sequential byte 3", d, 8'h19);
      recv_byte(1'b0, d); check("R6 released after master nack", d, 8'hFF);
      bus_stop();
      bus_start();
      send_byte(DEVR, d[0]); check("R7 current read ack", d[0], 1);
      recv_byte(1'b0, d); check("R7 current read is last plus one", d, 8'h1A);
      bus_stop();
      set_read_addr(8'h4F);
      recv_byte(1'b1, d); check("R7 page end byte", d, 8'h21);
      recv_byte(1'b0, d); check("R7 read crosses page", d, 8'hFF);
      bus_stop();
   endtask

   task automatic t_wrap_and_reset();
      logic k;
      logic [7:0] d;
      bus_start();
      send_byte(DEVW, k); send_byte(8'h00, k); send_byte(8'h5A, k);
      bus_stop();
      set_read_addr(8'hFF);
      recv_byte(1'b1, d); check("R7 byte at FFh", d, 8'hFF);
      recv_byte(1'b0, d); check("R7 pointer wraps to 00h", d, 8'h5A);
      bus_stop();
      rst_n = 1'b0; idle(4); rst_n = 1'b1; idle(4);
      bus_start();
      send_byte(DEVR, k);
      recv_byte(1'b0, d); check("R12 pointer 00h after reset", d, 8'h5A);
      bus_stop();
   endtask

   task automatic t_bad_addr();
      logic k;
      int c0 = commit_cnt;
      bus_start();
      send_byte({4'b0110, STRAP, 1'b0}, k); check("R1 wrong type no ack", k, 0);
      bus_stop();
      bus_start();
      send_byte({4'b1010, 3'b100, 1'b0}, k); check("R1 wrong strap no ack", k, 0);
      send_byte(8'h20, k); check("R1 later byte ignored", k, 0);
      send_byte(8'h77, k); check("R1 data ignored", k, 0);
      bus_stop();
      check("R1 no commit after mismatch", commit_cnt - c0, 0);
   endtask

   task automatic t_abandon();
      logic k;
      logic [7:0] d;
      int c0 = commit_cnt;
      bus_start(); bus_stop();
      bus_start();
      send_byte(DEVW, k); send_byte(8'h60, k); send_byte(8'h11, k);
      bus_start(); bus_stop();
      check("R9 abandoned write not committed", commit_cnt - c0, 0);
      set_read_addr(8'h60);
      recv_byte(1'b0, d); check("R9 location unchanged", d, 8'hFF);
      bus_stop();
   endtask

   task automatic t_busy();
      logic k;
      seq_busy = 1'b1;
      bus_start(); send_byte(DEVW, k); check("R10 no ack while busy", k, 0); bus_stop();
      seq_busy = 1'b0;
      bus_start(); send_byte(DEVW, k); check("R10 ack once idle", k, 1); bus_stop();
   endtask

   task automatic t_ack_allow();
      logic k;
      logic [7:0] d;
      int c0 = commit_cnt;
      ack_allow = 1'b0;
      bus_start();
      send_byte(DEVW, k);  check("R11 device ack", k, 1);
      send_byte(8'h70, k); check("R11 word ack", k, 1);
      send_byte(8'h33, k); check("R11 refused data no ack", k, 0);
      send_byte(8'h44, k); check("R11 rest ignored", k, 0);
      bus_stop();
      ack_allow = 1'b1;
      check("R11 no commit", commit_cnt - c0, 0);
      set_read_addr(8'h70);
      recv_byte(1'b0, d); check("R11 refused byte not stored", d, 8'hFF);
      bus_stop();
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(5);
      t_reset();
      t_byte_write();
      t_page_wrap();
      t_random_read();
      t_wrap_and_reset();
      t_bad_addr();
      t_abandon();
      t_busy();
      t_ack_allow();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule